// File: doc/BRIEF.md
# Loop Replay Buffer

This block sits in a processor front end between the decoder and the issue stage. It watches the stream of decoded operations. Each operation carries an operation word, its PC, a taken flag and a branch target. A taken branch whose target is at or below its own PC marks a possible loop. The block records the operations that follow, starting at that target. When the same branch is seen taken to the same target again, it has a complete loop body. If that body fits the storage and holds few enough taken branches, the block switches to replay mode.

In replay mode the upstream stream is stalled, so the cache and decoders sit idle. The recorded body is emitted as an endless cyclic sequence, four operations per group. The read position wraps from the last recorded operation to the first inside a single group, so even a loop shorter than a group fills every lane. A mispredict or redirect pulse drops the recorded body and returns the block to pass-through. In pass-through each incoming operation is forwarded alone in lane 0.

Both streaming edges use valid/ready. An input operation is taken on a clock edge where `in_valid` and `in_ready` are both high. An output group is consumed on an edge where `out_valid` and `out_ready` are both high. In pass-through, `in_ready` mirrors `out_ready`, so stalls pass straight upstream. In replay mode, `in_ready` is low. A group that is not consumed is presented again unchanged on the next cycle.

Top module: `loop_replay_buf`

## Requirements
- R1: While reset is held and after it is released, `out_streaming` is 0, `out_valid` equals `in_valid`, and `out_cnt` is 1 when `in_valid` is high and 0 otherwise.
- R2: In pass-through, lane 0 of `out_ops`/`out_pcs` carries `in_op`/`in_pc`, `out_cnt` is 1 when `in_valid` is high, and `in_ready` equals `out_ready`.
- R3: An accepted taken op with `in_target` <= `in_pc` starts recording at `in_target`. When the same PC is later accepted taken to the same target, `out_streaming` rises on the next cycle. That op itself still passes through.
- R4: In replay mode, `out_valid` is 1, `out_cnt` is 4 and `in_ready` is 0. Lane k (bits k*32 and up) holds the recorded op whose position is the read position plus k, taken modulo the body length. The first group starts at the loop head.
- R5: In replay mode, while `out_ready` is low the read position holds and the same group is presented again. Each accepted group advances the position by 4, modulo the body length.
- R6: A body of up to 18 ops is replayed. A body that would need a 19th slot is dropped, and the block stays in pass-through.
- R7: A body with at most 4 taken ops, counting the closing branch, is replayed. A body with a 5th taken op is dropped.
- R8: A pulse on `mispredict` or `redirect` clears replay mode and any recording in progress from the next cycle on. The same closing branch seen afterwards does not start replay.
- R9: Recording is dropped if the first op accepted after the backward branch is not at that branch's target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded op offered |
| in_ready | output | 1 | Op accepted this cycle |
| in_op | input | 32 | Decoded operation word |
| in_pc | input | 32 | PC of the op |
| in_taken | input | 1 | Op is a taken branch |
| in_target | input | 32 | Branch target when taken |
| mispredict | input | 1 | Branch mispredict flush |
| redirect | input | 1 | External fetch redirect |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_cnt | output | 3 | Number of valid lanes, from lane 0 |
| out_ops | output | 128 | Four op words, lane 0 in the low bits |
| out_pcs | output | 128 | Four PCs, lane 0 in the low bits |
| out_streaming | output | 1 | Replay mode active |

## Verification
A behavioural queue model runs beside the design and is compared on every cycle. The tests use loops of 5, 1 and 18 ops. The 5-op loop shows whether wrapping happens inside a group. The 1-op loop repeats a single entry across all lanes. The 18-op loop fills the storage exactly. Two bodies are one step over a limit, a 19-op body and a body with five taken ops, and they separate the accept and reject boundaries. Stalls during replay, flushes during recording and during replay, and a wrong-start sequence show that the pointer holds and that the recorded state is really dropped.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_FILL = 2'd1,
    LB_PLAY = 2'd2
  } lb_mode_e;
endpackage

// File: rtl/lbr_capture.sv
module lbr_capture
  import lbr_pkg::*;
#(
  parameter int DEPTH = 18,
  parameter int MAXTK = 4,
  parameter int PCW   = 32,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(MAXTK + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           acc,
  input  logic [PCW-1:0] in_pc,
  input  logic           in_taken,
  input  logic [PCW-1:0] in_target,
  output lb_mode_e       mode,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [IW-1:0]  body_len
);
  logic [PCW-1:0] anchor_pc, head_pc;
  logic [IW-1:0]  fill_cnt;
  logic [TW-1:0]  tk_cnt;
  logic           backward, closes, slot_ok;
  logic [TW-1:0]  tk_next;

  assign backward = in_taken && (in_target <= in_pc);
  assign closes   = in_taken && (in_pc == anchor_pc) && (in_target == head_pc);
  assign tk_next  = tk_cnt + TW'(1);
  assign slot_ok  = (fill_cnt < IW'(DEPTH)) && ((fill_cnt != '0) || (in_pc == head_pc));
  assign wr_en    = (mode == LB_FILL) && acc && !flush && slot_ok;
  assign wr_idx   = fill_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= LB_IDLE;
      anchor_pc <= '0;
      head_pc   <= '0;
      fill_cnt  <= '0;
      tk_cnt    <= '0;
      body_len  <= '0;
    end else if (flush) begin
      mode     <= LB_IDLE;
      fill_cnt <= '0;
      tk_cnt   <= '0;
    end else begin
      unique case (mode)
        LB_IDLE: if (acc && backward) begin
          anchor_pc <= in_pc;
          head_pc   <= in_target;
          fill_cnt  <= '0;
          tk_cnt    <= '0;
          mode      <= LB_FILL;
        end
        LB_FILL: if (acc) begin
          if (!slot_ok) begin
            mode <= LB_IDLE;
          end else if (closes) begin
            body_len <= fill_cnt + IW'(1);
            mode     <= LB_PLAY;
          end else if (in_taken && (tk_next >= TW'(MAXTK))) begin
            mode <= LB_IDLE;
          end else begin
            fill_cnt <= fill_cnt + IW'(1);
            if (in_taken) tk_cnt <= tk_next;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: any flush leaves the recorder idle on the following cycle
  assert_flush_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (mode == LB_IDLE));
  // R6: a replayed body is never empty and never longer than the storage
  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_PLAY) |-> (body_len != '0) && (body_len <= IW'(DEPTH)));
  // R7: recording never holds as many non-closing taken ops as the limit
  assert_tk_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LB_FILL) |-> (tk_cnt < TW'(MAXTK)));
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
  parameter int DEPTH = 18,
  parameter int LANES = 4,
  parameter int OPW   = 32,
  parameter int PCW   = 32,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [OPW-1:0]       wr_op,
  input  logic [PCW-1:0]       wr_pc,
  input  logic [LANES*IW-1:0]  rd_idx,
  output logic [LANES*OPW-1:0] rd_op,
  output logic [LANES*PCW-1:0] rd_pc
);
  logic [OPW-1:0] op_mem [DEPTH];
  logic [PCW-1:0] pc_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      op_mem[wr_idx] <= wr_op;
      pc_mem[wr_idx] <= wr_pc;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_port
    assign rd_op[g*OPW +: OPW] = op_mem[rd_idx[g*IW +: IW]];
    assign rd_pc[g*PCW +: PCW] = pc_mem[rd_idx[g*IW +: IW]];
  end
endmodule

// File: rtl/lbr_reader.sv
module lbr_reader #(
  parameter int DEPTH = 18,
  parameter int LANES = 4,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                play,
  input  logic                advance,
  input  logic [IW-1:0]       body_len,
  output logic [LANES*IW-1:0] lane_idx
);
  logic [IW-1:0] rd_pos, nxt_pos;

  always_comb begin
    logic [IW-1:0] walk;
    walk = rd_pos;
    for (int i = 0; i < LANES; i++) begin
      lane_idx[i*IW +: IW] = walk;
      walk = (walk + IW'(1) == body_len) ? '0 : walk + IW'(1);
    end
    nxt_pos = walk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !play) rd_pos <= '0;
    else if (advance)    rd_pos <= nxt_pos;
  end

  // R4: the read position always lies inside the recorded body
  assert_pos_in_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
    play |-> (rd_pos < body_len));
  // R5: without an accepted group the position does not move
  assert_pos_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (play && !advance) |=> (rd_pos == $past(rd_pos)) || !play);
endmodule

// File: rtl/loop_replay_buf.sv
module loop_replay_buf
  import lbr_pkg::*;
#(
  parameter int DEPTH = 18,
  parameter int LANES = 4,
  parameter int MAXTK = 4,
  parameter int OPW   = 32,
  parameter int PCW   = 32,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [OPW-1:0]       in_op,
  input  logic [PCW-1:0]       in_pc,
  input  logic                 in_taken,
  input  logic [PCW-1:0]       in_target,
  input  logic                 mispredict,
  input  logic                 redirect,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CW-1:0]        out_cnt,
  output logic [LANES*OPW-1:0] out_ops,
  output logic [LANES*PCW-1:0] out_pcs,
  output logic                 out_streaming
);
  lb_mode_e               mode;
  logic                   flush, play, acc, wr_en;
  logic [IW-1:0]          wr_idx, body_len;
  logic [LANES*IW-1:0]    lane_idx;
  logic [LANES*OPW-1:0]   rd_op;
  logic [LANES*PCW-1:0]   rd_pc;

  assign flush = mispredict | redirect;
  assign play  = (mode == LB_PLAY);
  assign in_ready = !play && out_ready;
  assign acc   = in_valid && in_ready;

  lbr_capture #(.DEPTH(DEPTH), .MAXTK(MAXTK), .PCW(PCW)) u_cap (
    .clk(clk), .rst_n(rst_n), .flush(flush), .acc(acc),
    .in_pc(in_pc), .in_taken(in_taken), .in_target(in_target),
    .mode(mode), .wr_en(wr_en), .wr_idx(wr_idx), .body_len(body_len)
  );

  lbr_store #(.DEPTH(DEPTH), .LANES(LANES), .OPW(OPW), .PCW(PCW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_op(in_op), .wr_pc(in_pc),
    .rd_idx(lane_idx), .rd_op(rd_op), .rd_pc(rd_pc)
  );

  lbr_reader #(.DEPTH(DEPTH), .LANES(LANES)) u_rd (
    .clk(clk), .rst_n(rst_n), .play(play),
    .advance(play && out_ready && !flush),
    .body_len(body_len), .lane_idx(lane_idx)
  );

  always_comb begin
    if (play) begin
      out_valid = 1'b1;
      out_cnt   = CW'(LANES);
      out_ops   = rd_op;
      out_pcs   = rd_pc;
    end else begin
      out_valid = in_valid;
      out_cnt   = in_valid ? CW'(1) : '0;
      out_ops   = '0;
      out_pcs   = '0;
      out_ops[OPW-1:0] = in_op;
      out_pcs[PCW-1:0] = in_pc;
    end
  end
  assign out_streaming = play;

  // R4: the upstream stream is stalled during replay
  assert_no_intake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_streaming |-> !in_ready);
  // R5: a stalled replay group is re-presented unchanged
  assert_stall_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_streaming && !out_ready && !flush) |=> $stable(out_ops) && $stable(out_pcs));
  // R3: replay can only begin right after an op was accepted
  assert_enter_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_streaming) |-> $past(acc));
  // R2: lane count never exceeds the group width
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CW'(LANES));
endmodule

// File: tb/loop_replay_buf_test.sv
module loop_replay_buf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_taken = 1'b0, mispredict = 1'b0, redirect = 1'b0, out_ready = 1'b1;
  logic [31:0] in_op = '0, in_pc = '0, in_target = '0;
  logic in_ready, out_valid, out_streaming;
  logic [2:0] out_cnt;
  logic [127:0] out_ops, out_pcs;

  always #10 clk = ~clk;

  loop_replay_buf uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_pc(in_pc), .in_taken(in_taken), .in_target(in_target),
    .mispredict(mispredict), .redirect(redirect), .out_valid(out_valid),
    .out_ready(out_ready), .out_cnt(out_cnt), .out_ops(out_ops),
    .out_pcs(out_pcs), .out_streaming(out_streaming)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference: 0 idle, 1 recording, 2 replay
  int m_mode = 0, m_rd = 0, m_tk = 0;
  logic [31:0] m_anchor = '0, m_head = '0;
  logic [31:0] q_op[$], q_pc[$];

  function automatic logic [31:0] opw(input logic [31:0] pc);
    return pc ^ 32'hC0DE0000;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit play;
    int sz;
    play = (m_mode == 2);
    chk(cur_req, "out_streaming", 64'(out_streaming), 64'(play));
    chk(cur_req, "out_valid", 64'(out_valid), play ? 64'd1 : 64'(in_valid));
    chk(cur_req, "in_ready", 64'(in_ready), 64'(!play && out_ready));
    if (play) begin
      sz = q_op.size();
      chk(cur_req, "out_cnt", 64'(out_cnt), 64'd4);
      for (int i = 0; i < 4; i++) begin
        chk(cur_req, "lane op", 64'(out_ops[i*32 +: 32]), 64'(q_op[(m_rd + i) % sz]));
        chk(cur_req, "lane pc", 64'(out_pcs[i*32 +: 32]), 64'(q_pc[(m_rd + i) % sz]));
      end
    end else begin
      chk(cur_req, "out_cnt", 64'(out_cnt), in_valid ? 64'd1 : 64'd0);
      if (in_valid) begin
        chk(cur_req, "lane0 op", 64'(out_ops[31:0]), 64'(in_op));
        chk(cur_req, "lane0 pc", 64'(out_pcs[31:0]), 64'(in_pc));
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n || mispredict || redirect) begin
      m_mode = 0; m_rd = 0; m_tk = 0; q_op.delete(); q_pc.delete();
    end else if (m_mode == 0) begin
      if (in_valid && out_ready && in_taken && in_target <= in_pc) begin
        m_anchor = in_pc; m_head = in_target; m_tk = 0;
        q_op.delete(); q_pc.delete(); m_mode = 1;
      end
    end else if (m_mode == 1) begin
      if (in_valid && out_ready) begin
        if (q_op.size() >= 18 || (q_op.size() == 0 && in_pc != m_head)) m_mode = 0;
        else begin
          q_op.push_back(in_op); q_pc.push_back(in_pc);
          if (in_taken) begin
            if (in_pc == m_anchor && in_target == m_head) begin m_mode = 2; m_rd = 0; end
            else begin m_tk++; if (m_tk >= 4) m_mode = 0; end
          end
        end
      end
    end else if (out_ready) begin
      m_rd = (m_rd + 4) % q_op.size();
    end
  end

  task automatic tick();
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic drive_op(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    in_valid = 1'b1; in_pc = pc; in_op = opw(pc); in_taken = tk; in_target = tg;
    tick();
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_taken = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic body(input logic [31:0] base, input int n, input int xtk);
    for (int k = 0; k < n; k++) begin
      logic [31:0] pc;
      pc = base + 32'(4 * k);
      if (k == n - 1)  drive_op(pc, 1'b1, base);
      else if (k < xtk) drive_op(pc, 1'b1, pc + 32'd4);
      else              drive_op(pc, 1'b0, '0);
    end
    in_valid = 1'b0;
  endtask

  task automatic pulse_redirect(input bit use_mp);
    in_valid = 1'b0;
    if (use_mp) mispredict = 1'b1; else redirect = 1'b1;
    tick();
    mispredict = 1'b0; redirect = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    idle(2);
    chk("R1", "streaming in reset", 64'(out_streaming), 64'd0);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "out_cnt idle", 64'(out_cnt), 64'd0);

    cur_req = "R2";
    drive_op(32'h0000_0100, 1'b0, '0);
    drive_op(32'h0000_0104, 1'b0, '0);
    out_ready = 1'b0;
    in_valid = 1'b1; #1;
    chk("R2", "in_ready follows out_ready", 64'(in_ready), 64'd0);
    tick();
    out_ready = 1'b1;
    idle(1);

    cur_req = "R3";
    body(32'h0000_1000, 5, 0);
    body(32'h0000_1000, 5, 0);
    cur_req = "R4";
    #1;
    chk("R3", "replay entered", 64'(out_streaming), 64'd1);
    chk("R4", "group0 lane0 pc", 64'(out_pcs[31:0]), 64'h1000);
    chk("R4", "group0 lane3 pc", 64'(out_pcs[127:96]), 64'h100C);
    tick();
    #1;
    chk("R4", "wrap lane0 pc", 64'(out_pcs[31:0]), 64'h1010);
    chk("R4", "wrap lane1 pc", 64'(out_pcs[63:32]), 64'h1000);
    tick();
    cur_req = "R5";
    out_ready = 1'b0;
    idle(3);
    out_ready = 1'b1;
    idle(4);
    cur_req = "R8";
    pulse_redirect(1'b1);
    #1;
    chk("R8", "mispredict exits replay", 64'(out_streaming), 64'd0);
    body(32'h0000_1000, 5, 0);
    #1;
    chk("R8", "closing branch alone no replay", 64'(out_streaming), 64'd0);
    idle(1);
    pulse_redirect(1'b0);

    cur_req = "R4";
    body(32'h0000_2000, 1, 0);
    body(32'h0000_2000, 1, 0);
    idle(3);
    pulse_redirect(1'b0);

    cur_req = "R6";
    body(32'h0000_3000, 18, 0);
    body(32'h0000_3000, 18, 0);
    #1;
    chk("R6", "18-op body replayed", 64'(out_streaming), 64'd1);
    idle(6);
    pulse_redirect(1'b0);
    body(32'h0000_4000, 19, 0);
    body(32'h0000_4000, 19, 0);
    #1;
    chk("R6", "19-op body dropped", 64'(out_streaming), 64'd0);
    idle(1);
    pulse_redirect(1'b0);

    cur_req = "R7";
    body(32'h0000_5000, 8, 3);
    body(32'h0000_5000, 8, 3);
    #1;
    chk("R7", "four taken replayed", 64'(out_streaming), 64'd1);
    idle(3);
    pulse_redirect(1'b0);
    body(32'h0000_6000, 8, 4);
    body(32'h0000_6000, 8, 4);
    #1;
    chk("R7", "five taken dropped", 64'(out_streaming), 64'd0);
    idle(1);
    pulse_redirect(1'b0);

    cur_req = "R9";
    drive_op(32'h0000_7200, 1'b1, 32'h0000_7100);
    drive_op(32'h0000_7300, 1'b0, '0);
    drive_op(32'h0000_7304, 1'b0, '0);
    drive_op(32'h0000_7200, 1'b1, 32'h0000_7100);
    idle(1);
    chk("R9", "wrong start no replay", 64'(out_streaming), 64'd0);

    cur_req = "R8";
    pulse_redirect(1'b0);
    body(32'h0000_8000, 4, 0);
    drive_op(32'h0000_8000, 1'b0, '0);
    pulse_redirect(1'b0);
    body(32'h0000_8000, 4, 0);
    #1;
    chk("R8", "redirect drops recording", 64'(out_streaming), 64'd0);
    idle(2);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule